// File: doc/BRIEF.md
# Timer Compare Output Unit

This unit watches a 16-bit free-running timer and compares it on every clock with a programmable compare value. When the timer first equals that value, the unit acts according to a 4-bit mode field. It can drive an output pin high or low, it can set only the interrupt flag, or it can emit a one-cycle special-event pulse. That pulse is meant to clear the external timer and, if conversions are enabled, to start an analog conversion.

Software programs the unit through a small write port. Address 0 loads the compare value, address 1 loads the mode, and address 2 clears the interrupt flag. When the pin is not owned by a drive mode, it follows the port data latch. When software moves the unit into one of the two drive modes from any other mode, the pin is preset low at once. Moving between the two drive modes keeps the current level. This allows a pin to be forced high first and then armed to go low on the next match.

Top module: `cmp_out_unit`

## Requirements
- R1: After synchronous reset, pin_drv, pin_oe, irq_flag, evt_pulse and conv_start are all 0. The mode is 4'b0000 and the compare value is all ones.
- R2: A match exists only when all 16 timer bits equal the compare value. It is acted on once, at the first clock edge where the equality holds. A timer that stays equal produces no further match.
- R3: In mode 4'b1000, a match drives pin_drv to 1 at the clock edge that sees the match.
- R4: In mode 4'b1001, a match drives pin_drv to 0 at the clock edge that sees the match.
- R5: A mode write of 4'b1000 or 4'b1001, made while the current mode is neither of those two, drives pin_drv to 0 at that edge, whatever port_latch holds.
- R6: A mode write that switches between 4'b1000 and 4'b1001 leaves pin_drv at its current level until the next match.
- R7: A match in any mode 4'b10xx sets irq_flag. A match in modes 4'b0xxx or 4'b11xx does not. Once set, irq_flag stays set until a write to address 2.
- R8: In all modes other than 4'b1000 and 4'b1001, pin_drv takes the value of port_latch one edge later, and a match does not change it.
- R9: In mode 4'b1011, a match raises evt_pulse for exactly one cycle. conv_start rises in the same cycle only when conv_en is 1.
- R10: If a flag-clear write and a flag-setting match land on the same edge, irq_flag ends set.
- R11: pin_oe follows pin_dir_out one edge later.
- R12: Writes use wr_addr 0 for the compare value (wr_data[15:0]), 1 for the mode (wr_data[3:0]) and 2 for the flag clear. A write to address 3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tmr_val | input | 16 | Current timer count |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select |
| wr_data | input | 16 | Write data |
| port_latch | input | 1 | Port data latch value |
| pin_dir_out | input | 1 | 1 selects the pin as an output |
| conv_en | input | 1 | Allows the special event to start a conversion |
| pin_drv | output | 1 | Level presented to the pin |
| pin_oe | output | 1 | Pin output enable |
| irq_flag | output | 1 | Compare interrupt flag |
| evt_pulse | output | 1 | Special-event pulse (timer clear) |
| conv_start | output | 1 | Conversion start request |

## Verification
A flag-clear write can fall on the same edge as a match that sets the flag. The bench provokes this by driving the equal timer value and the address-2 write in the same cycle, and it expects the flag to read set afterwards. A mode write that enters a drive mode can also coincide with pin ownership passing from the port latch. This is judged by holding the latch high and checking that the pin reads low right after the write.

// File: rtl/cmp_pkg.sv
package cmp_pkg;
  localparam int MODE_W = 4;
  localparam int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] A_CMPVAL = 2'd0;
  localparam logic [ADDR_W-1:0] A_MODE   = 2'd1;
  localparam logic [ADDR_W-1:0] A_FLGCLR = 2'd2;

  localparam logic [MODE_W-1:0] M_SET_HI = 4'b1000;
  localparam logic [MODE_W-1:0] M_SET_LO = 4'b1001;
  localparam logic [MODE_W-1:0] M_FLAG   = 4'b1010;
  localparam logic [MODE_W-1:0] M_SPEVT  = 4'b1011;

  function automatic logic is_drive(input logic [MODE_W-1:0] m);
    return m[3:1] == 3'b100;
  endfunction

  function automatic logic is_cmp(input logic [MODE_W-1:0] m);
    return m[3:2] == 2'b10;
  endfunction
endpackage

// File: rtl/cmp_regs.sv
module cmp_regs
  import cmp_pkg::*;
#(
  parameter int TMR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [TMR_W-1:0]  wr_data,
  output logic [TMR_W-1:0]  cmp_val,
  output logic [MODE_W-1:0] mode_q,
  output logic              mode_wr,
  output logic [MODE_W-1:0] mode_new,
  output logic              flag_clr
);
  logic cmp_wr;

  always_comb begin
    cmp_wr   = wr_en && (wr_addr == A_CMPVAL);
    mode_wr  = wr_en && (wr_addr == A_MODE);
    flag_clr = wr_en && (wr_addr == A_FLGCLR);
    mode_new = wr_data[MODE_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp_val <= '1;
      mode_q  <= '0;
    end else begin
      if (cmp_wr)  cmp_val <= wr_data;
      if (mode_wr) mode_q  <= mode_new;
    end
  end

  // R12: a write to an unused address leaves the mode alone
  assert_addr3_no_mode_R12: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == 2'd3) |=> $stable(mode_q));
endmodule

// File: rtl/cmp_match.sv
module cmp_match #(
  parameter int TMR_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [TMR_W-1:0] tmr_val,
  input  logic [TMR_W-1:0] cmp_val,
  output logic             match
);
  logic eq, eq_q;

  always_comb begin
    eq    = (tmr_val == cmp_val);
    match = eq && !eq_q;
  end

  always_ff @(posedge clk) begin
    if (rst) eq_q <= 1'b0;
    else     eq_q <= eq;
  end

  assert_single_match_R2: assert property (@(posedge clk) disable iff (rst)
    match |=> !match);
endmodule

// File: rtl/cmp_pin.sv
module cmp_pin
  import cmp_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [MODE_W-1:0] mode_q,
  input  logic              mode_wr,
  input  logic [MODE_W-1:0] mode_new,
  input  logic              match,
  input  logic              port_latch,
  input  logic              pin_dir_out,
  output logic              pin_drv,
  output logic              pin_oe
);
  logic              drv_q, drv_nxt;
  logic [MODE_W-1:0] mode_eff;
  logic              entering;

  always_comb begin
    mode_eff = mode_wr ? mode_new : mode_q;
    entering = mode_wr && is_drive(mode_new) && !is_drive(mode_q);
    drv_nxt  = drv_q;
    if (match && mode_q == M_SET_HI) drv_nxt = 1'b1;
    if (match && mode_q == M_SET_LO) drv_nxt = 1'b0;
    if (entering)                    drv_nxt = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      drv_q   <= 1'b0;
      pin_drv <= 1'b0;
      pin_oe  <= 1'b0;
    end else begin
      drv_q   <= drv_nxt;
      pin_drv <= is_drive(mode_eff) ? drv_nxt : port_latch;
      pin_oe  <= pin_dir_out;
    end
  end

  assert_entry_low_R5: assert property (@(posedge clk) disable iff (rst)
    (mode_wr && is_drive(mode_new) && !is_drive(mode_q)) |=> !pin_drv);
  assert_hi_on_match_R3: assert property (@(posedge clk) disable iff (rst)
    (match && mode_q == M_SET_HI && !mode_wr) |=> pin_drv);
  assert_lo_on_match_R4: assert property (@(posedge clk) disable iff (rst)
    (match && mode_q == M_SET_LO && !mode_wr) |=> !pin_drv);
  assert_latch_follow_R8: assert property (@(posedge clk) disable iff (rst)
    (!is_drive(mode_q) && !mode_wr) |=> (pin_drv == $past(port_latch)));
  assert_oe_follow_R11: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (pin_oe == $past(pin_dir_out)));
endmodule

// File: rtl/cmp_out_unit.sv
module cmp_out_unit
  import cmp_pkg::*;
#(
  parameter int TMR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [TMR_W-1:0]  tmr_val,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [TMR_W-1:0]  wr_data,
  input  logic              port_latch,
  input  logic              pin_dir_out,
  input  logic              conv_en,
  output logic              pin_drv,
  output logic              pin_oe,
  output logic              irq_flag,
  output logic              evt_pulse,
  output logic              conv_start
);
  logic [TMR_W-1:0]  cmp_val;
  logic [MODE_W-1:0] mode_q, mode_new;
  logic              mode_wr, flag_clr, match, spev;

  cmp_regs #(.TMR_W(TMR_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cmp_val(cmp_val), .mode_q(mode_q), .mode_wr(mode_wr),
    .mode_new(mode_new), .flag_clr(flag_clr)
  );

  cmp_match #(.TMR_W(TMR_W)) u_match (
    .clk(clk), .rst(rst), .tmr_val(tmr_val), .cmp_val(cmp_val), .match(match)
  );

  cmp_pin u_pin (
    .clk(clk), .rst(rst), .mode_q(mode_q), .mode_wr(mode_wr),
    .mode_new(mode_new), .match(match), .port_latch(port_latch),
    .pin_dir_out(pin_dir_out), .pin_drv(pin_drv), .pin_oe(pin_oe)
  );

  always_comb spev = match && (mode_q == M_SPEVT);

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_flag   <= 1'b0;
      evt_pulse  <= 1'b0;
      conv_start <= 1'b0;
    end else begin
      if (match && is_cmp(mode_q)) irq_flag <= 1'b1;
      else if (flag_clr)           irq_flag <= 1'b0;
      evt_pulse  <= spev;
      conv_start <= spev && conv_en;
    end
  end

  assert_flag_on_match_R7: assert property (@(posedge clk) disable iff (rst)
    (match && is_cmp(mode_q)) |=> irq_flag);
  assert_flag_wins_R10: assert property (@(posedge clk) disable iff (rst)
    (match && is_cmp(mode_q) && flag_clr) |=> irq_flag);
  assert_evt_one_cycle_R9: assert property (@(posedge clk) disable iff (rst)
    evt_pulse |=> !evt_pulse);
  assert_conv_needs_evt_R9: assert property (@(posedge clk) disable iff (rst)
    conv_start |-> evt_pulse);
endmodule

// File: tb/tb_cmp_out_unit.sv
module tb_cmp_out_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] tmr_val = 16'h0000;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = 2'd0;
  logic [15:0] wr_data = 16'h0000;
  logic        port_latch = 1'b0;
  logic        pin_dir_out = 1'b0;
  logic        conv_en = 1'b0;
  logic        pin_drv, pin_oe, irq_flag, evt_pulse, conv_start;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  cmp_out_unit dut (
    .clk(clk), .rst(rst), .tmr_val(tmr_val), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .port_latch(port_latch), .pin_dir_out(pin_dir_out),
    .conv_en(conv_en), .pin_drv(pin_drv), .pin_oe(pin_oe), .irq_flag(irq_flag),
    .evt_pulse(evt_pulse), .conv_start(conv_start)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %b expected %b", req, what, act, exp);
    end
  endtask

  // drive on a falling edge, let one rising edge pass, return at the next falling edge
  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic tick(input logic [15:0] t);
    tmr_val = t;
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1", "pin_drv", pin_drv, 1'b0);
    chk("R1", "pin_oe", pin_oe, 1'b0);
    chk("R1", "irq_flag", irq_flag, 1'b0);
    chk("R1", "evt_pulse", evt_pulse, 1'b0);
    chk("R1", "conv_start", conv_start, 1'b0);
    port_latch = 1'b1; pin_dir_out = 1'b1;
    tick(16'hFFFF);
    chk("R8", "pin follows latch in mode 0000", pin_drv, 1'b1);
    chk("R7", "no flag in mode 0000", irq_flag, 1'b0);
    chk("R11", "oe follows dir", pin_oe, 1'b1);
  endtask

  task automatic t_set_high();
    wr(2'd0, 16'h1234);
    wr(2'd1, 16'h0008);
    chk("R5", "entry to 1000 presets low", pin_drv, 1'b0);
    tick(16'h1233);
    chk("R3", "no match yet", pin_drv, 1'b0);
    tick(16'h1234);
    chk("R3", "match drives high", pin_drv, 1'b1);
    chk("R7", "flag on match", irq_flag, 1'b1);
    wr(2'd2, 16'h0000);
    chk("R7", "flag cleared by write", irq_flag, 1'b0);
    tick(16'h1234);
    tick(16'h1234);
    chk("R2", "held equality no refire", irq_flag, 1'b0);
    tick(16'h9234);
    chk("R2", "upper bit differs no match", irq_flag, 1'b0);
    tick(16'h1235);
    tick(16'h1234);
    chk("R2", "new equality fires", irq_flag, 1'b1);
  endtask

  task automatic t_switch_low();
    tick(16'h0100);
    wr(2'd1, 16'h0009);
    chk("R6", "1000 to 1001 keeps high", pin_drv, 1'b1);
    tick(16'h0101);
    chk("R6", "still high before match", pin_drv, 1'b1);
    tick(16'h1234);
    chk("R4", "match drives low", pin_drv, 1'b0);
  endtask

  task automatic t_flag_mode();
    tick(16'h0000);
    port_latch = 1'b1;
    wr(2'd1, 16'h000A);
    chk("R8", "1010 pin follows latch", pin_drv, 1'b1);
    wr(2'd2, 16'h0000);
    tick(16'h1234);
    chk("R7", "1010 sets flag", irq_flag, 1'b1);
    chk("R8", "1010 match leaves pin", pin_drv, 1'b1);
    port_latch = 1'b0;
    tick(16'h0000);
    chk("R8", "1010 latch low", pin_drv, 1'b0);
    port_latch = 1'b1;
    tick(16'h0000);
    wr(2'd1, 16'h0008);
    chk("R5", "entry from 1010 low despite latch", pin_drv, 1'b0);
  endtask

  task automatic t_special();
    wr(2'd1, 16'h000B);
    conv_en = 1'b1;
    tick(16'h1234);
    chk("R9", "evt pulse", evt_pulse, 1'b1);
    chk("R9", "conv start enabled", conv_start, 1'b1);
    chk("R7", "flag in special mode", irq_flag, 1'b1);
    tick(16'h0000);
    chk("R9", "evt one cycle", evt_pulse, 1'b0);
    chk("R9", "conv one cycle", conv_start, 1'b0);
    conv_en = 1'b0;
    tick(16'h1234);
    chk("R9", "evt with conv off", evt_pulse, 1'b1);
    chk("R9", "conv blocked", conv_start, 1'b0);
    tick(16'h0000);
  endtask

  task automatic t_inactive();
    wr(2'd1, 16'h000C);
    wr(2'd2, 16'h0000);
    port_latch = 1'b0;
    tick(16'h1234);
    chk("R7", "no flag in 1100", irq_flag, 1'b0);
    chk("R8", "1100 pin follows latch", pin_drv, 1'b0);
    tick(16'h0000);
  endtask

  task automatic t_same_cycle();
    wr(2'd1, 16'h000A);
    tmr_val = 16'h1234;
    wr(2'd2, 16'h0000);
    chk("R10", "set beats clear", irq_flag, 1'b1);
    tick(16'h0000);
  endtask

  task automatic t_addr3();
    port_latch = 1'b1;
    wr(2'd1, 16'h0008);
    chk("R5", "entry low", pin_drv, 1'b0);
    wr(2'd3, 16'h0000);
    chk("R12", "addr 3 no pin change", pin_drv, 1'b0);
    tick(16'h0000);
    chk("R12", "compare kept after addr 3", pin_drv, 1'b0);
    tick(16'h1234);
    chk("R12", "mode and compare kept", pin_drv, 1'b1);
    pin_dir_out = 1'b0;
    tick(16'h0000);
    chk("R11", "oe off", pin_oe, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_set_high();
    t_switch_low();
    t_flag_mode();
    t_special();
    t_inactive();
    t_same_cycle();
    t_addr3();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule